// File: doc/BRIEF.md
# Bus-Master ATA DMA Engine

This block moves data between system memory and a two-drive ATA channel without processor involvement. Software programs a command register, a status register and a 32-bit table pointer through a small register port. The table pointer addresses a list of two-word descriptors in memory. Once software sets the run bit, the engine walks that list and streams words in the direction it was given. The drive command is issued first and the run bit is set afterwards, so the engine accepts a start at any moment after setup.

Memory is reached through a single-outstanding request/acknowledge interface that can return an error response. The drive side is a valid/ready word handshake in each direction, plus a drive-interrupt input. Software judges the outcome from the low three status bits. The value 3'b100 (interrupt seen, engine idle, no error) means success, and any other value means the transfer went wrong. The interrupt output mirrors the interrupt status bit.

Top module: `bmdma_engine`

## Requirements
- R1: After reset the command, status and table-pointer registers read 0, `irq` is 0 and no memory request is raised.
- R2: Register select 0 is the command register, 1 is status and 2 is the 32-bit table pointer. A read returns data in the cycle after the read strobe. A command write that takes bit 0 from 0 to 1 starts fetching descriptors at the table pointer.
- R3: Each descriptor is two words. Word 0 is the buffer byte address, and word 1 holds the byte count in bits [CNT_W-1:0] (0 means 2^CNT_W bytes) and the end-of-table flag in bit 31. With command bit 3 = 1, drive words are written to successive memory words of the buffer in order. With command bit 3 = 0, buffer words are read and handed to the drive in order.
- R4: When the count of a descriptor without bit 31 runs out, the next descriptor is fetched 8 bytes further on. When the count of a descriptor with bit 31 runs out, status bit 0 clears and no memory word past the count is touched.
- R5: Writing command bit 0 as 0 halts the engine. Status bit 0 clears and no further memory request or drive transfer takes place.
- R6: Status bit 0 reads 1 exactly while the engine is working through the table.
- R7: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 to either leaves it unchanged.
- R8: Status bits 5 and 6 (drive 0 and drive 1 DMA-capable) read back the value last written and are not changed by the engine.
- R9: A rising edge on `drv_irq` sets status bit 2, and `irq` equals status bit 2.
- R10: A memory error response sets status bit 1, stops the transfer and clears status bit 0, so the low three bits no longer read 3'b100.
- R11: Status bits 4 and 3 are read-only. Both read 1 while the engine is active and waiting on the drive for a word, and both read 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt, follows status bit 2 |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| dev_in_valid | input | 1 | Drive offers a word |
| dev_in_data | input | DATA_W | Word from the drive |
| dev_in_ready | output | 1 | Engine accepts a drive word |
| dev_out_valid | output | 1 | Engine offers a word to the drive |
| dev_out_data | output | DATA_W | Word for the drive |
| dev_out_ready | input | 1 | Drive accepts the word |
| drv_irq | input | 1 | Drive interrupt request |

## Verification
The bench builds the engine with DATA_W = 32 and CNT_W reduced to 8. With that width a descriptor count of zero stands for 256 bytes, so the full-length case is reached after only 64 words. Both directions, descriptor chaining, an abort while the engine waits on the drive, and an error response in the middle of a buffer are all covered within a short run. The memory responder and the drive models stall and resume on command, which makes the waiting bits observable.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  // register select codes on the host port
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_PTR  = 2'd2;

  // command and status bit positions
  localparam int CMD_RUN   = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP0   = 5;
  localparam int N_DRV     = 2;

  localparam int DESC_END  = 31;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_ADDR,
    S_FETCH_CNT,
    S_DEV_IN,
    S_MEM_WR,
    S_MEM_RD,
    S_DEV_OUT
  } bm_state_e;

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busy_i,
  input  logic        waiting_i,
  input  logic        err_set_i,
  input  logic        drv_irq_i,
  output logic        run_o,
  output logic        start_o,
  output logic        start_tomem_o,
  output logic [31:0] ptr_o,
  output logic        irq_o
);

  logic             run_q, tomem_q, err_q, intr_q, drv_q;
  logic [N_DRV-1:0] cap_q;
  logic [31:0]      ptr_q, rdata_q;

  wire wr_cmd  = wr_en && (addr == SEL_CMD);
  wire wr_stat = wr_en && (addr == SEL_STAT);
  wire wr_ptr  = wr_en && (addr == SEL_PTR);

  assign start_o       = wr_cmd && wdata[CMD_RUN] && !run_q;
  assign start_tomem_o = wdata[CMD_TOMEM];
  assign run_o         = run_q;
  assign ptr_o         = ptr_q;
  assign irq_o         = intr_q;
  assign rdata         = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      tomem_q <= 1'b0;
      err_q   <= 1'b0;
      intr_q  <= 1'b0;
      drv_q   <= 1'b0;
      ptr_q   <= '0;
      rdata_q <= '0;
    end else begin
      drv_q <= drv_irq_i;
      if (wr_cmd) begin
        run_q   <= wdata[CMD_RUN];
        tomem_q <= wdata[CMD_TOMEM];
      end
      if (wr_ptr) ptr_q <= wdata;
      // set events win over a same-cycle clear
      if (err_set_i)                        err_q <= 1'b1;
      else if (wr_stat && wdata[ST_ERR])    err_q <= 1'b0;
      if (drv_irq_i && !drv_q)              intr_q <= 1'b1;
      else if (wr_stat && wdata[ST_INT])    intr_q <= 1'b0;
      if (rd_en) begin
        case (addr)
          SEL_CMD:  rdata_q <= {28'd0, tomem_q, 2'b00, run_q};
          SEL_STAT: rdata_q <= {25'd0, cap_q, waiting_i, waiting_i,
                                intr_q, err_q, busy_i};
          SEL_PTR:  rdata_q <= ptr_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  // one plain storage bit per drive
  for (genvar d = 0; d < N_DRV; d++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)          cap_q[d] <= 1'b0;
      else if (wr_stat) cap_q[d] <= wdata[ST_CAP0 + d];
    end
  end

  AST_ERR_W1C_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_stat && wdata[ST_ERR])) |=> err_q);  // R7

  AST_INT_W1C_HOLD: assert property (@(posedge clk) disable iff (rst)
    (intr_q && !(wr_stat && wdata[ST_INT])) |=> intr_q);  // R7

  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> $stable(cap_q));  // R8

endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              start_tomem_i,
  input  logic [31:0]       ptr_i,
  output logic              busy_o,
  output logic              waiting_o,
  output logic              err_set_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready
);

  localparam int                 BYTES = DATA_W / 8;
  localparam int                 REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0]   STEP  = REM_W'(BYTES);
  localparam logic [REM_W-1:0]   FULL  = {1'b1, {CNT_W{1'b0}}};
  localparam logic [31:0]        AMASK = ~(32'(BYTES) - 32'd1);

  bm_state_e         st_q;
  logic [31:0]       tbl_q, buf_q;
  logic [REM_W-1:0]  rem_q;
  logic              last_q, tomem_q;
  logic [DATA_W-1:0] data_q;

  logic unused_desc;
  assign unused_desc = ^mem_rdata[30:CNT_W];

  wire acked    = mem_req && mem_ack;
  wire good_ack = acked && !mem_err;
  wire word_done = (st_q == S_MEM_WR && good_ack) ||
                   (st_q == S_DEV_OUT && dev_out_ready);

  assign busy_o        = (st_q != S_IDLE);
  assign waiting_o     = (st_q == S_DEV_IN) || (st_q == S_DEV_OUT);
  assign err_set_o     = acked && mem_err && run_i && !start_i;
  assign mem_req       = (st_q == S_FETCH_ADDR) || (st_q == S_FETCH_CNT) ||
                         (st_q == S_MEM_WR) || (st_q == S_MEM_RD);
  assign mem_we        = (st_q == S_MEM_WR);
  assign mem_wdata     = data_q;
  assign dev_in_ready  = (st_q == S_DEV_IN);
  assign dev_out_valid = (st_q == S_DEV_OUT);
  assign dev_out_data  = data_q;

  always_comb begin
    case (st_q)
      S_FETCH_ADDR: mem_addr = tbl_q;
      S_FETCH_CNT:  mem_addr = tbl_q + 32'd4;
      default:      mem_addr = buf_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      tbl_q   <= '0;
      buf_q   <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
      tomem_q <= 1'b0;
      data_q  <= '0;
    end else if (start_i) begin
      tbl_q   <= ptr_i & 32'hFFFF_FFFC;
      tomem_q <= start_tomem_i;
      st_q    <= S_FETCH_ADDR;
    end else if (!run_i) begin
      st_q <= S_IDLE;
    end else if (acked && mem_err) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_FETCH_ADDR: if (good_ack) begin
          buf_q <= mem_rdata[31:0] & AMASK;
          st_q  <= S_FETCH_CNT;
        end
        S_FETCH_CNT: if (good_ack) begin
          rem_q  <= (mem_rdata[CNT_W-1:0] == '0) ? FULL
                                                 : {1'b0, mem_rdata[CNT_W-1:0]};
          last_q <= mem_rdata[DESC_END];
          tbl_q  <= tbl_q + 32'd8;
          st_q   <= tomem_q ? S_DEV_IN : S_MEM_RD;
        end
        S_DEV_IN: if (dev_in_valid) begin
          data_q <= dev_in_data;
          st_q   <= S_MEM_WR;
        end
        S_MEM_RD: if (good_ack) begin
          data_q <= mem_rdata;
          st_q   <= S_DEV_OUT;
        end
        default: ;
      endcase
      if (word_done) begin
        buf_q <= buf_q + 32'(BYTES);
        rem_q <= rem_q - STEP;
        if (rem_q <= STEP) st_q <= last_q ? S_IDLE : S_FETCH_ADDR;
        else               st_q <= tomem_q ? S_DEV_IN : S_MEM_RD;
      end
    end
  end

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);  // R2

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !start_i) |=> (!busy_o && !mem_req));  // R5

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    (acked && mem_err && !start_i) |=> !busy_o);  // R10

endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  input  logic              drv_irq
);

  logic        busy, waiting, err_set, run, start, start_tomem;
  logic [31:0] ptr;

  bmdma_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr),
    .rd_en        (reg_rd),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .rdata        (reg_rdata),
    .busy_i       (busy),
    .waiting_i    (waiting),
    .err_set_i    (err_set),
    .drv_irq_i    (drv_irq),
    .run_o        (run),
    .start_o      (start),
    .start_tomem_o(start_tomem),
    .ptr_o        (ptr),
    .irq_o        (irq)
  );

  bmdma_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .run_i        (run),
    .start_i      (start),
    .start_tomem_i(start_tomem),
    .ptr_i        (ptr),
    .busy_o       (busy),
    .waiting_o    (waiting),
    .err_set_o    (err_set),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_err      (mem_err),
    .mem_rdata    (mem_rdata),
    .dev_in_valid (dev_in_valid),
    .dev_in_data  (dev_in_data),
    .dev_in_ready (dev_in_ready),
    .dev_out_valid(dev_out_valid),
    .dev_out_data (dev_out_data),
    .dev_out_ready(dev_out_ready)
  );

  AST_WAIT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == SEL_STAT) |=>
      (reg_rdata[3] == reg_rdata[4]) && (!reg_rdata[3] || reg_rdata[ST_ACT]));  // R11

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_irq) |=> irq);  // R9

  AST_IDLE_NO_XFER: assert property (@(posedge clk) disable iff (rst)
    (!busy) |-> (!mem_req && !dev_in_ready && !dev_out_valid));  // R6

endmodule

// File: tb/bmdma_engine_tb_top.sv
module bmdma_engine_tb_top;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq;
  logic              mem_req, mem_we;
  logic [31:0]       mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0, mem_err = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              dev_in_valid = 1'b0;
  logic [DATA_W-1:0] dev_in_data = '0;
  logic              dev_in_ready;
  logic              dev_out_valid;
  logic [DATA_W-1:0] dev_out_data;
  logic              dev_out_ready = 1'b0;
  logic              drv_irq = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bmdma_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0, wr_count = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [63:0] exp_wr_q[$];
  logic [31:0] exp_out_q[$];
  logic [31:0] src_q[$];
  bit feed_en = 1'b0;

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // memory responder and write scoreboard (R3)
  always @(negedge clk) begin
    if (rst || mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      mem_err = (mem_addr == err_addr);
      if (!mem_err) begin
        if (mem_we) begin
          wr_count++;
          if (exp_wr_q.size() == 0) begin
            check_eq("R3", "unexpected memory write addr", mem_addr, 32'hFFFF_FFFF);
          end else begin
            logic [63:0] e;
            e = exp_wr_q.pop_front();
            check_eq("R3", "write address", mem_addr, e[63:32]);
            check_eq("R3", "write data", mem_wdata, e[31:0]);
          end
          mem[mem_addr[11:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
        end
      end
    end
  end

  // drive source model
  always @(negedge clk) begin
    if (feed_en && src_q.size() > 0) begin
      dev_in_valid = 1'b1;
      dev_in_data  = src_q[0];
      if (dev_in_ready) void'(src_q.pop_front());
    end else begin
      dev_in_valid = 1'b0;
    end
  end

  // drive sink monitor (R3)
  always @(negedge clk) begin
    if (dev_out_valid && dev_out_ready) begin
      if (exp_out_q.size() == 0)
        check_eq("R3", "unexpected drive word", dev_out_data, 32'hFFFF_FFFF);
      else
        check_eq("R3", "drive word", dev_out_data, exp_out_q.pop_front());
    end
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd1, s);
      if (!s[0]) break;
    end
  endtask

  // driver: queue the memory writes a to-memory buffer must produce
  task automatic plan_tomem(logic [31:0] base, int words, logic [31:0] seed);
    for (int i = 0; i < words; i++) begin
      logic [31:0] w;
      w = seed + 32'(i) * 32'h0101_0101;
      src_q.push_back(w);
      exp_wr_q.push_back({base + 32'(4 * i), w});
    end
  endtask

  task automatic plan_frommem(logic [31:0] base, int words);
    for (int i = 0; i < words; i++)
      exp_out_q.push_back(mem[(base >> 2) + 32'(i)]);
  endtask

  initial begin
    logic [31:0] v;
    int wc;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + 32'(i);
    mem[32'h30C >> 2] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(2'd0, v); check_eq("R1", "cmd after reset", v, 32'h0);
    reg_read(2'd1, v); check_eq("R1", "status after reset", v, 32'h0);
    reg_read(2'd2, v); check_eq("R1", "pointer after reset", v, 32'h0);
    check_eq("R1", "irq after reset", {31'd0, irq}, 32'h0);
    check_eq("R1", "mem_req after reset", {31'd0, mem_req}, 32'h0);

    // R2 R3 R4 R11: two descriptors, drive to memory
    mem[32'h100 >> 2] = 32'h200; mem[32'h104 >> 2] = 32'h8;
    mem[32'h108 >> 2] = 32'h300; mem[32'h10C >> 2] = 32'h8000_000C;
    reg_write(2'd2, 32'h100);
    reg_read(2'd2, v); check_eq("R2", "pointer readback", v, 32'h100);
    reg_write(2'd0, 32'h08);
    reg_write(2'd0, 32'h09);
    repeat (20) @(negedge clk);
    reg_read(2'd1, v); check_eq("R11", "waiting on drive", v, 32'h19);
    reg_write(2'd1, 32'h18);
    reg_read(2'd1, v); check_eq("R11", "read-only wait bits", v, 32'h19);
    plan_tomem(32'h200, 2, 32'h1111_0000);
    plan_tomem(32'h300, 3, 32'h2222_0000);
    feed_en = 1'b1;
    wait_idle();
    feed_en = 1'b0;
    reg_read(2'd1, v); check_eq("R4", "status after end of table", v, 32'h0);
    check_eq("R3", "writes left over", 32'(exp_wr_q.size()), 32'h0);
    check_eq("R4", "word past count untouched", mem[32'h30C >> 2], 32'hDEAD_BEEF);

    // R9 R7 interrupt
    @(negedge clk); drv_irq = 1'b1;
    repeat (2) @(negedge clk); drv_irq = 1'b0;
    reg_read(2'd1, v); check_eq("R9", "interrupt bit, good completion", v, 32'h04);
    check_eq("R9", "irq output set", {31'd0, irq}, 32'h1);
    reg_write(2'd1, 32'h00);
    reg_read(2'd1, v); check_eq("R7", "zero write keeps interrupt", v, 32'h04);
    reg_write(2'd1, 32'h04);
    reg_read(2'd1, v); check_eq("R7", "one write clears interrupt", v, 32'h00);
    check_eq("R9", "irq output cleared", {31'd0, irq}, 32'h0);

    // R8 capability bits
    reg_write(2'd1, 32'h60);
    reg_read(2'd1, v); check_eq("R8", "both capability bits", v, 32'h60);
    reg_write(2'd1, 32'h40);
    reg_read(2'd1, v); check_eq("R8", "drive 1 capability only", v, 32'h40);

    // R3 R4 memory to drive, zero count = 256 bytes
    mem[32'h180 >> 2] = 32'h800; mem[32'h184 >> 2] = 32'h8000_0000;
    plan_frommem(32'h800, 64);
    reg_write(2'd0, 32'h00);
    reg_write(2'd2, 32'h180);
    dev_out_ready = 1'b1;
    reg_write(2'd0, 32'h01);
    wait_idle();
    reg_read(2'd1, v); check_eq("R8", "capability kept through transfer", v, 32'h40);
    check_eq("R3", "drive words left over", 32'(exp_out_q.size()), 32'h0);

    // R5 stop while waiting on drive
    mem[32'h1C0 >> 2] = 32'h400; mem[32'h1C4 >> 2] = 32'h8000_0010;
    mem[32'h400 >> 2] = 32'h5555_5555;
    reg_write(2'd0, 32'h00);
    reg_write(2'd2, 32'h1C0);
    reg_write(2'd0, 32'h09);
    repeat (20) @(negedge clk);
    reg_read(2'd1, v); check_eq("R6", "active while transferring", v, 32'h59);
    reg_write(2'd0, 32'h08);
    reg_read(2'd1, v); check_eq("R5", "status after stop", v, 32'h40);
    wc = wr_count;
    src_q.push_back(32'h7777_7777);
    feed_en = 1'b1;
    repeat (20) @(negedge clk);
    check_eq("R5", "no writes after stop", 32'(wr_count - wc), 32'h0);
    check_eq("R5", "no request after stop", {31'd0, mem_req}, 32'h0);
    check_eq("R5", "buffer untouched", mem[32'h400 >> 2], 32'h5555_5555);
    feed_en = 1'b0;
    src_q.delete();

    // R10 error response on second buffer word, then R7 on error bit
    mem[32'h1E0 >> 2] = 32'h500; mem[32'h1E4 >> 2] = 32'h8000_0010;
    err_addr = 32'h504;
    plan_frommem(32'h500, 1);
    reg_write(2'd0, 32'h00);
    reg_write(2'd2, 32'h1E0);
    reg_write(2'd0, 32'h01);
    repeat (40) @(negedge clk);
    reg_read(2'd1, v); check_eq("R10", "error stops engine", v, 32'h42);
    check_eq("R10", "words before error", 32'(exp_out_q.size()), 32'h0);
    reg_write(2'd1, 32'h40);
    reg_read(2'd1, v); check_eq("R7", "zero write keeps error", v, 32'h42);
    reg_write(2'd1, 32'h42);
    reg_read(2'd1, v); check_eq("R7", "one write clears error", v, 32'h40);
    err_addr = 32'hFFFF_FFFF;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule